// File: doc/BRIEF.md
# Two-Channel Interleaved Buck Switch Sequencer

This block is the digital timing core behind two synchronous step-down converter channels. For each channel it produces two gate-enable levels. One is for the high-side switch and one is for the low-side synchronous rectifier. The analog parts stay outside the block. A regulation comparator and a current-limit comparator report trips, and the gate drivers receive the enables.

A single free-running period counter provides the cycle start for both channels. The second channel starts its cycle half a period after the first, so the two input-current pulses do not coincide. Each cycle runs in a fixed order. The rectifier turns off, a dead interval passes, and then the high-side switch turns on. It turns off on the first accepted trip. A second dead interval follows, and the rectifier then conducts until the next cycle start. A per-channel full-duty request keeps the high-side switch on. A thermal fault from either channel stops switching in both channels. A disabled channel keeps both of its switches off.

Top module: `buck_phase_seq`

## Requirements
- R1: While `rst_n` is low, and in the first clock after it, all four gate outputs are 0.
- R2: A cycle start turns the rectifier off on that clock edge. The high-side switch turns on DEAD_CLKS (default 2) edges later. Both gates are 0 in between.
- R3: The high-side switch turns off on the edge where either `reg_trip` or `ilim_trip` of its channel is sampled high. After DEAD_CLKS further edges, with both gates 0 in between, the rectifier turns on.
- R4: The rectifier stays on until the next cycle start of its channel.
- R5: Edge 1 is the first rising edge sampled with `rst_n` high. With PERIOD_CLKS = P (default 16), channel 0 cycle starts fall on edges 1, 1+P, 1+2P, and so on. Channel 1 cycle starts fall P/2 edges later (edges 1+P/2, ...).
- R6: While `full_duty` of a channel is high, its high-side switch stays on and its trips are ignored. A cycle start that arrives while the high-side switch is on leaves it on.
- R7: A high `therm_fault` on either bit turns off all four gates on the next edge. Once the fault clears, each enabled channel restarts at its next cycle start.
- R8: A channel whose `ch_enable` bit is low has both gates 0 from the next edge. The other channel is not affected. When the bit returns high, the channel restarts at its next cycle start.
- R9: A trip sampled on the first MIN_ON_CLKS (default 1) edges after the high-side switch turned on is ignored.
- R10: The high-side and low-side gates of one channel are never 1 together. A gate never rises on the edge right after its partner was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ch_enable | input | 2 | Per-channel enable, bit 0 is the master channel |
| reg_trip | input | 2 | Regulation comparator trip per channel |
| ilim_trip | input | 2 | Current-limit comparator trip per channel |
| therm_fault | input | 2 | Thermal fault per channel, stops both channels |
| full_duty | input | 2 | 100% duty request per channel |
| hs_gate | output | 2 | High-side switch gate enable per channel |
| ls_gate | output | 2 | Low-side rectifier gate enable per channel |

## Verification
Every gate output is a registered decode of channel state, so a change caused by an input is seen after the edge that samples that input. Trip, fault and disable responses therefore show one edge later. A rectifier turn-on after a trip, and a high-side turn-on after a cycle start, show DEAD_CLKS edges later. The bench numbers the edges from reset release and drives inputs on falling edges. It queues each expected gate level against the edge number after which it is due. A monitor compares the levels on the falling edge following that numbered rising edge. The bench samples one edge early to confirm that dead intervals and ignored trips leave the gates unchanged.

// File: rtl/buck_seq_pkg.sv
// Package: shared types for the two-channel buck switch sequencer.
// Assumes exactly two phase-interleaved channels.
package buck_seq_pkg;

    localparam int NUM_CH = 2;

    // Switching phase of one channel; gate outputs decode from this.
    typedef enum logic [2:0] {
        SW_IDLE   = 3'd0,
        SW_DEAD_H = 3'd1,
        SW_HIGH   = 3'd2,
        SW_DEAD_L = 3'd3,
        SW_LOW    = 3'd4
    } sw_phase_e;

endpackage

// File: rtl/buck_seq_phase_gen.sv
// Module: buck_seq_phase_gen
// Free-running period counter that produces one cycle-start strobe per
// channel. Channel 0 strobes at count 0, channel 1 at count PERIOD_CLKS/2.
// Assumes PERIOD_CLKS >= 4 so that both strobes are distinct.
module buck_seq_phase_gen #(
    parameter int PERIOD_CLKS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    output logic [1:0] start_tick
);
    localparam int CW       = (PERIOD_CLKS > 1) ? $clog2(PERIOD_CLKS) : 1;
    localparam int HALF_CNT = PERIOD_CLKS / 2;
    localparam logic [CW-1:0] LAST_CNT = CW'(PERIOD_CLKS - 1);
    localparam logic [CW-1:0] HALF_VAL = CW'(HALF_CNT);

    logic [CW-1:0] period_cnt;

    // Advance the period counter and wrap at the last count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period_cnt <= '0;
        end else if (period_cnt == LAST_CNT) begin
            period_cnt <= '0;
        end else begin
            period_cnt <= period_cnt + 1'b1;
        end
    end

    // Decode the master and the half-period-shifted strobes.
    always_comb begin
        start_tick[0] = (period_cnt == '0);
        start_tick[1] = (period_cnt == HALF_VAL);
    end

endmodule

// File: rtl/buck_seq_chan.sv
// Module: buck_seq_chan
// Switch sequencer for one channel. A cycle start takes it through a dead
// interval into the high-side phase. An accepted trip ends that phase and
// leads through a second dead interval into the rectifier phase, which lasts
// until the next cycle start. Trips inside the minimum on-time are ignored.
// A full-duty request holds the high-side phase. A low run input forces idle.
// Assumes DEAD_CLKS >= 1 and MIN_ON_CLKS >= 0.
module buck_seq_chan
    import buck_seq_pkg::*;
#(
    parameter int DEAD_CLKS   = 2,
    parameter int MIN_ON_CLKS = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic cyc_start,
    input  logic trip_any,
    input  logic hold_high,
    output logic hs_on,
    output logic ls_on
);
    localparam int DW = $clog2(DEAD_CLKS + 1);
    localparam int OW = $clog2(MIN_ON_CLKS + 2);
    localparam logic [DW-1:0] DEAD_LOAD = DW'(DEAD_CLKS - 1);
    localparam logic [OW-1:0] ON_SAT    = OW'(MIN_ON_CLKS);

    sw_phase_e     phase_q;
    sw_phase_e     phase_d;
    logic [DW-1:0] dead_cnt;
    logic [OW-1:0] on_cnt;
    logic          load_dead;
    logic          clr_on;
    logic          dead_done;
    logic          on_min_met;

    assign dead_done  = (dead_cnt == '0);
    assign on_min_met = (on_cnt == ON_SAT);

    // Next-phase selection and counter control for this channel.
    always_comb begin
        phase_d   = phase_q;
        load_dead = 1'b0;
        clr_on    = 1'b0;
        if (!run) begin
            phase_d = SW_IDLE;
        end else begin
            case (phase_q)
                SW_IDLE: begin
                    if (cyc_start) begin
                        phase_d   = SW_DEAD_H;
                        load_dead = 1'b1;
                    end
                end
                SW_DEAD_H: begin
                    if (dead_done) begin
                        phase_d = SW_HIGH;
                        clr_on  = 1'b1;
                    end
                end
                SW_HIGH: begin
                    if (!hold_high && trip_any && on_min_met) begin
                        phase_d   = SW_DEAD_L;
                        load_dead = 1'b1;
                    end
                end
                SW_DEAD_L: begin
                    if (cyc_start) begin
                        phase_d   = SW_DEAD_H;
                        load_dead = 1'b1;
                    end else if (dead_done) begin
                        phase_d = SW_LOW;
                    end
                end
                SW_LOW: begin
                    if (cyc_start) begin
                        phase_d   = SW_DEAD_H;
                        load_dead = 1'b1;
                    end
                end
                default: phase_d = SW_IDLE;
            endcase
        end
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= SW_IDLE;
        end else begin
            phase_q <= phase_d;
        end
    end

    // Dead-interval down-counter, reloaded on entry to a dead phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dead_cnt <= '0;
        end else if (load_dead) begin
            dead_cnt <= DEAD_LOAD;
        end else if (!dead_done) begin
            dead_cnt <= dead_cnt - 1'b1;
        end
    end

    // Saturating on-time counter that gates trip acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            on_cnt <= '0;
        end else if (clr_on) begin
            on_cnt <= '0;
        end else if (phase_q == SW_HIGH && !on_min_met) begin
            on_cnt <= on_cnt + 1'b1;
        end
    end

    // Gate levels decode directly from the registered phase.
    always_comb begin
        hs_on = (phase_q == SW_HIGH);
        ls_on = (phase_q == SW_LOW);
    end

endmodule

// File: rtl/buck_phase_seq.sv
// Module: buck_phase_seq (top)
// Two-channel interleaved buck switch sequencer. A shared period counter
// strobes channel 0 at count 0 and channel 1 half a period later. A thermal
// fault on either channel stops both, and each channel's enable gates only
// that channel. Assumes all inputs are already synchronous to clk.
module buck_phase_seq
    import buck_seq_pkg::*;
#(
    parameter int PERIOD_CLKS = 16,
    parameter int DEAD_CLKS   = 2,
    parameter int MIN_ON_CLKS = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] ch_enable,
    input  logic [1:0] reg_trip,
    input  logic [1:0] ilim_trip,
    input  logic [1:0] therm_fault,
    input  logic [1:0] full_duty,
    output logic [1:0] hs_gate,
    output logic [1:0] ls_gate
);
    logic [1:0] tick_w;
    logic       any_fault;

    // A fault on either channel removes run from both.
    assign any_fault = |therm_fault;

    buck_seq_phase_gen #(
        .PERIOD_CLKS(PERIOD_CLKS)
    ) u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_tick(tick_w)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        buck_seq_chan #(
            .DEAD_CLKS  (DEAD_CLKS),
            .MIN_ON_CLKS(MIN_ON_CLKS)
        ) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .run      (ch_enable[c] & ~any_fault),
            .cyc_start(tick_w[c]),
            .trip_any (reg_trip[c] | ilim_trip[c]),
            .hold_high(full_duty[c]),
            .hs_on    (hs_gate[c]),
            .ls_on    (ls_gate[c])
        );
    end

endmodule

// File: rtl/buck_phase_seq_chk.sv
// Module: buck_phase_seq_chk
// Property checker for buck_phase_seq, attached through bind below.
module buck_phase_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] ch_enable,
    input logic [1:0] therm_fault,
    input logic [1:0] full_duty,
    input logic [1:0] hs_gate,
    input logic [1:0] ls_gate,
    input logic [1:0] tick
);
    for (genvar c = 0; c < 2; c++) begin : g_chk
        a_r10_ls_after_hs_off: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ls_gate[c]) |-> !$past(hs_gate[c]));
        a_r10_hs_after_ls_off: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(hs_gate[c]) |-> !$past(ls_gate[c]));
        a_r7_fault_stops_all: assert property (@(posedge clk) disable iff (!rst_n)
            (|therm_fault) |=> (!hs_gate[c] && !ls_gate[c]));
        a_r8_disable_off: assert property (@(posedge clk) disable iff (!rst_n)
            !ch_enable[c] |=> (!hs_gate[c] && !ls_gate[c]));
        a_r6_full_duty_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (hs_gate[c] && full_duty[c] && ch_enable[c] && !(|therm_fault)) |=> hs_gate[c]);
        a_r4_ls_until_start: assert property (@(posedge clk) disable iff (!rst_n)
            (ls_gate[c] && !tick[c] && ch_enable[c] && !(|therm_fault)) |=> ls_gate[c]);
        a_r9_min_on: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(hs_gate[c]) && ch_enable[c] && !(|therm_fault)) |=> hs_gate[c]);
    end
endmodule

bind buck_phase_seq buck_phase_seq_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ch_enable  (ch_enable),
    .therm_fault(therm_fault),
    .full_duty  (full_duty),
    .hs_gate    (hs_gate),
    .ls_gate    (ls_gate),
    .tick       (tick_w)
);

// File: tb/buck_phase_seq_tb_top.sv
// Scoreboard bench: expected gate levels are queued against edge numbers,
// and a falling-edge monitor compares them as those edges pass.
module buck_phase_seq_tb_top;

    typedef struct {
        int    cyc;
        int    ch;
        bit    hs;
        bit    ls;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] ch_enable = 2'b11;
    logic [1:0] reg_trip = 2'b00;
    logic [1:0] ilim_trip = 2'b00;
    logic [1:0] therm_fault = 2'b00;
    logic [1:0] full_duty = 2'b00;
    logic [1:0] hs_gate;
    logic [1:0] ls_gate;

    int   cyc = 0;
    int   n_tests = 0;
    int   n_fail = 0;
    int   overlap_err = 0;
    exp_t sb_q[$];

    buck_phase_seq #(.PERIOD_CLKS(16), .DEAD_CLKS(2), .MIN_ON_CLKS(1)) dut_i (
        .clk(clk), .rst_n(rst_n), .ch_enable(ch_enable), .reg_trip(reg_trip),
        .ilim_trip(ilim_trip), .therm_fault(therm_fault), .full_duty(full_duty),
        .hs_gate(hs_gate), .ls_gate(ls_gate)
    );

    always #4 clk = ~clk;

    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    task automatic expect_at(input int c, input int ch, input bit hs, input bit ls, input string tag);
        exp_t e;
        e.cyc = c; e.ch = ch; e.hs = hs; e.ls = ls; e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic wait_cyc(input int k);
        @(negedge clk);
        while (cyc != k) @(negedge clk);
    endtask

    // Monitor: compare due items and count gate overlaps.
    always @(negedge clk) begin
        if (rst_n) begin
            for (int i = sb_q.size() - 1; i >= 0; i--) begin
                if (sb_q[i].cyc == cyc) begin
                    n_tests++;
                    if (hs_gate[sb_q[i].ch] !== sb_q[i].hs || ls_gate[sb_q[i].ch] !== sb_q[i].ls) begin
                        n_fail++;
                        $display("FAIL %s edge %0d ch%0d: hs/ls actual %b/%b expected %b/%b",
                                 sb_q[i].tag, cyc, sb_q[i].ch, hs_gate[sb_q[i].ch],
                                 ls_gate[sb_q[i].ch], sb_q[i].hs, sb_q[i].ls);
                    end
                    sb_q.delete(i);
                end
            end
            if ((hs_gate & ls_gate) != 2'b00) overlap_err++;
        end
    end

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        // R2, R5: start timing
        expect_at(1, 0, 0, 0, "R1"); expect_at(2, 0, 0, 0, "R2"); expect_at(3, 0, 1, 0, "R2");
        expect_at(9, 1, 0, 0, "R5"); expect_at(10, 1, 0, 0, "R5"); expect_at(11, 1, 1, 0, "R5");
        // R3: regulation trip, dead, rectifier
        expect_at(7, 0, 1, 0, "R3"); expect_at(8, 0, 0, 0, "R3"); expect_at(9, 0, 0, 0, "R3");
        expect_at(10, 0, 0, 1, "R3");
        // R3: current-limit trip on channel 1
        expect_at(14, 1, 0, 0, "R3"); expect_at(15, 1, 0, 0, "R3"); expect_at(16, 1, 0, 1, "R3");
        // R4: rectifier until next start
        expect_at(16, 0, 0, 1, "R4"); expect_at(17, 0, 0, 0, "R4"); expect_at(18, 0, 0, 0, "R4");
        expect_at(19, 0, 1, 0, "R4");
        // R9: minimum on-time
        expect_at(20, 0, 1, 0, "R9"); expect_at(21, 0, 0, 0, "R9");
        // R6: full duty
        expect_at(27, 1, 1, 0, "R6"); expect_at(30, 1, 1, 0, "R6"); expect_at(31, 1, 1, 0, "R6");
        expect_at(41, 1, 1, 0, "R6"); expect_at(45, 1, 1, 0, "R6"); expect_at(47, 1, 0, 0, "R6");
        expect_at(49, 1, 0, 1, "R6");
        // R7: thermal stop and restart
        expect_at(51, 0, 1, 0, "R7"); expect_at(52, 0, 0, 0, "R7"); expect_at(52, 1, 0, 0, "R7");
        expect_at(55, 0, 0, 0, "R7"); expect_at(55, 1, 0, 0, "R7"); expect_at(58, 1, 0, 0, "R7");
        expect_at(59, 1, 1, 0, "R7"); expect_at(64, 0, 0, 0, "R7"); expect_at(67, 0, 1, 0, "R7");
        // R8: per-channel disable
        expect_at(71, 0, 1, 0, "R8"); expect_at(72, 0, 0, 0, "R8"); expect_at(72, 1, 1, 0, "R8");
        expect_at(82, 0, 0, 0, "R8"); expect_at(83, 0, 1, 0, "R8");

        repeat (3) @(negedge clk);
        n_tests++;
        if (hs_gate !== 2'b00 || ls_gate !== 2'b00) begin
            n_fail++;
            $display("FAIL R1 reset: hs/ls actual %b/%b expected 00/00", hs_gate, ls_gate);
        end
        rst_n = 1'b1;

        wait_cyc(7);  reg_trip[0] = 1'b1;
        wait_cyc(8);  reg_trip[0] = 1'b0;
        wait_cyc(13); ilim_trip[1] = 1'b1;
        wait_cyc(14); ilim_trip[1] = 1'b0;
        wait_cyc(19); reg_trip[0] = 1'b1;
        wait_cyc(21); reg_trip[0] = 1'b0;
        wait_cyc(23); full_duty[1] = 1'b1;
        wait_cyc(29); reg_trip[1] = 1'b1;
        wait_cyc(30); reg_trip[1] = 1'b0;
        wait_cyc(45); full_duty[1] = 1'b0;
        wait_cyc(46); reg_trip[1] = 1'b1;
        wait_cyc(47); reg_trip[1] = 1'b0;
        wait_cyc(51); therm_fault[1] = 1'b1;
        wait_cyc(55); therm_fault[1] = 1'b0;
        wait_cyc(71); ch_enable[0] = 1'b0;
        wait_cyc(76); ch_enable[0] = 1'b1;
        wait_cyc(90);

        n_tests++;
        if (sb_q.size() != 0) begin
            n_fail++;
            $display("FAIL R2 scoreboard: actual %0d items left expected 0", sb_q.size());
        end
        n_tests++;
        if (overlap_err != 0) begin
            n_fail++;
            $display("FAIL R10 overlap: actual %0d cycles expected 0", overlap_err);
        end
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule